// File: doc/BRIEF.md
# Serial Page Write Sequencer

This block is a host-side bus master for a memory that accepts one bit per bus cycle on a single data pin. It takes a request made of a 16-bit target address, a byte count and bytes held in a small host buffer. It then runs the full write transaction on the chip-enable, write-strobe and read-strobe lines and the data pin. The transaction opens with a configurable preamble of bus cycles. The address follows, then the payload and a three-cycle commit pattern. After that the block polls the data pin until the memory reports that its internal write has finished.

Every bus cycle has a fixed shape counted in clock cycles: a setup phase, a strobe phase, a hold phase and a gap with chip enable high. The bus is therefore free for other masters between any two cycles. The block reads the payload through an index it drives into the host buffer. It reports progress with a busy level. It reports the outcome with exactly one of three single-cycle pulses: finished, polling timed out, or request rejected.

Top module: `pgwr_seq`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are all high (inactive), the data pin is not driven and busy is low.
- R2: A request whose byte count is 0 or greater than 32 raises the reject pulse for one cycle on the clock after it is presented, leaves busy low and starts no bus cycle.
- R3: An accepted request runs its bus cycles in this order: the preamble cycles, 16 address cycles, eight cycles per byte, the three commit cycles, then status reads. Nothing comes before or after them. With default parameters the preamble is read, write of 0, read.
- R4: Each address or payload bit is a write cycle. Chip enable and write strobe are low, read strobe is high and the data pin is driven with the bit, and the bit stays stable while the write strobe is low.
- R5: Address bits go out from bit 15 down to bit 0. Bytes go out starting at buffer index 0 and counting up, each from bit 7 down to bit 0.
- R6: No read cycle occurs between the first address cycle and the last payload cycle.
- R7: The commit pattern is a read cycle, then a write cycle with the pin at 1, then a read cycle.
- R8: Status reads sample the data pin at the end of the read strobe. A high sample ends the transaction with a one-cycle done pulse and busy falls in that same cycle. Busy is high from the cycle after acceptance until then.
- R9: If a number of status reads equal to the latched poll limit have all sampled low, the block raises the timeout pulse and issues no further bus cycle. A limit of 0 acts as a limit of 1.
- R10: The data pin output enable is high only inside write cycles. It is low during read cycles and whenever chip enable is high.
- R11: Write strobe and read strobe are never low together. Each chip-enable-low window holds exactly one strobe, and chip enable stays high for at least one clock between windows.
- R12: The done, timeout and reject pulses are each one cycle long and never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_addr | input | 16 | Target address |
| req_count | input | 6 | Number of bytes, valid range 1 to 32 |
| req_poll_limit | input | 16 | Maximum number of status reads |
| buf_idx | output | 5 | Index of the byte being sent |
| buf_byte | input | 8 | Buffer byte at buf_idx (combinational read) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse: write finished |
| err_timeout | output | 1 | One-cycle pulse: poll limit reached |
| err_reject | output | 1 | One-cycle pulse: byte count out of range |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_dq_out | output | 1 | Data pin output value |
| bus_dq_oe | output | 1 | Data pin output enable |
| bus_dq_in | input | 1 | Data pin input value |

## Verification
A wrong step counter or serializer state shows up as a misplaced or wrong bit in the logged cycle list, such as a swapped address bit, a skipped byte or a missing commit write. The check compares that list with the expected one built from the requirements, so the error is reported at the end of that same transaction. A strobe-framing fault, such as a driven pin during a read or two strobes in one chip-enable window, is caught within the clock cycle where it happens. A fault in the polling counter shows as a wrong number of status reads or the wrong outcome pulse. Because the model memory releases the pin after a chosen number of reads, this shows for both the success path and the timeout path.

// File: rtl/pgwr_pkg.sv
// Shared types for the serial page write sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pgwr_pkg;

    // Transaction-level step of the controller.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_ADDR,
        ST_DATA,
        ST_COMMIT,
        ST_POLL
    } seq_state_t;

    // Phase inside one bus cycle.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_GAP
    } bus_phase_t;

    // Description of one bus cycle handed to the cycle engine.
    typedef struct packed {
        logic is_write;
        logic wbit;
    } cyc_desc_t;

    // Largest of four phase lengths, used to size the phase counter.
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pgwr_bus_cycle.sv
// Bus cycle engine: runs one read or write cycle at a time with fixed
// setup, strobe, hold and gap lengths in clock cycles.
// Assumes every phase length is at least 1 and that go is only raised
// while the engine is idle. Read data is captured on the last strobe clock.
module pgwr_bus_cycle
    import pgwr_pkg::*;
#(
    parameter int T_SETUP  = 1,
    parameter int T_STROBE = 2,
    parameter int T_HOLD   = 1,
    parameter int T_GAP    = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      go,
    input  cyc_desc_t desc,
    input  logic      dq_in,
    output logic      ce_n,
    output logic      we_n,
    output logic      oe_n,
    output logic      dq_out,
    output logic      dq_oe,
    output logic      rd_bit,
    output logic      cyc_done
);

    localparam int TMAX = max4(T_SETUP, T_STROBE, T_HOLD, T_GAP);
    localparam int TW   = (TMAX > 1) ? $clog2(TMAX) : 1;

    bus_phase_t     phase;
    logic [TW-1:0]  cnt;
    cyc_desc_t      cur;
    logic           last_clk;

    assign last_clk = (cnt == '0);

    // Phase sequencing, cycle descriptor latch and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            cur    <= '0;
            rd_bit <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (go) begin
                        cur   <= desc;
                        phase <= PH_SETUP;
                        cnt   <= TW'(T_SETUP - 1);
                    end
                end
                PH_SETUP: begin
                    if (last_clk) begin
                        phase <= PH_STROBE;
                        cnt   <= TW'(T_STROBE - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (last_clk) begin
                        if (!cur.is_write) begin
                            rd_bit <= dq_in;
                        end
                        phase <= PH_HOLD;
                        cnt   <= TW'(T_HOLD - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last_clk) begin
                        phase <= PH_GAP;
                        cnt   <= TW'(T_GAP - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_GAP: begin
                    if (last_clk) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Pin levels decoded from the current phase and cycle kind.
    always_comb begin
        logic active;
        active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        ce_n   = !active;
        we_n   = !((phase == PH_STROBE) && cur.is_write);
        oe_n   = !((phase == PH_STROBE) && !cur.is_write);
        dq_oe  = active && cur.is_write;
        dq_out = dq_oe ? cur.wbit : 1'b0;
    end

    assign cyc_done = (phase == PH_GAP) && last_clk;

endmodule

// File: rtl/pgwr_serializer.sv
// Bit serializer: presents the address from its top bit down, then the
// payload bytes from index 0 upward, each from bit 7 down to bit 0.
// Assumes the buffer byte at buf_idx is valid combinationally and that
// step is raised once per completed address or payload cycle.
module pgwr_serializer #(
    parameter int ADDR_W    = 16,
    parameter int MAX_BYTES = 32,
    parameter int CNT_W     = 6,
    parameter int IDX_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  count,
    input  logic              step,
    input  logic [7:0]        buf_byte,
    output logic [IDX_W-1:0]  buf_idx,
    output logic              bit_out,
    output logic              addr_last,
    output logic              data_last
);

    localparam int ABW = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;

    logic [ADDR_W-1:0] addr_sr;
    logic [ABW-1:0]    abits_left;
    logic              in_data;
    logic [IDX_W-1:0]  byte_idx;
    logic [2:0]        bit_pos;
    logic [CNT_W-1:0]  count_q;

    // Load on acceptance, then advance one bit per completed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_sr    <= '0;
            abits_left <= '0;
            in_data    <= 1'b0;
            byte_idx   <= '0;
            bit_pos    <= 3'd7;
            count_q    <= '0;
        end else if (load) begin
            addr_sr    <= addr;
            abits_left <= ABW'(ADDR_W - 1);
            in_data    <= 1'b0;
            byte_idx   <= '0;
            bit_pos    <= 3'd7;
            count_q    <= count;
        end else if (step) begin
            if (!in_data) begin
                addr_sr <= addr_sr << 1;
                if (abits_left == '0) begin
                    in_data <= 1'b1;
                end else begin
                    abits_left <= abits_left - 1'b1;
                end
            end else if (bit_pos == 3'd0) begin
                bit_pos  <= 3'd7;
                byte_idx <= byte_idx + 1'b1;
            end else begin
                bit_pos <= bit_pos - 1'b1;
            end
        end
    end

    // Current bit and end-of-field flags.
    always_comb begin
        buf_idx   = byte_idx;
        bit_out   = in_data ? buf_byte[bit_pos] : addr_sr[ADDR_W-1];
        addr_last = !in_data && (abits_left == '0);
        data_last = in_data && (bit_pos == 3'd0) &&
                    (CNT_W'(byte_idx) == (count_q - 1'b1));
    end

endmodule

// File: rtl/pgwr_ctrl.sv
// Transaction controller: validates the request, then steps through the
// preamble, address, payload, commit and status polling, launching one
// bus cycle at a time and raising exactly one outcome pulse.
// Assumes RST_LEN is at least 1 and the engine signals each finished cycle.
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int               MAX_BYTES = 32,
    parameter int               CNT_W     = 6,
    parameter int               POLL_W    = 16,
    parameter int               RST_LEN   = 3,
    parameter logic [RST_LEN-1:0] RST_WR  = 3'b010,
    parameter logic [RST_LEN-1:0] RST_VAL = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [POLL_W-1:0] req_poll_limit,
    input  logic              cyc_done,
    input  logic              rd_bit,
    input  logic              addr_last,
    input  logic              data_last,
    input  logic              ser_bit,
    output logic              ser_load,
    output logic              ser_step,
    output logic              go,
    output cyc_desc_t         desc,
    output logic              busy,
    output logic              done,
    output logic              err_timeout,
    output logic              err_reject
);

    localparam int RW = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;

    seq_state_t        state;
    logic [RW-1:0]     rst_step;
    logic [1:0]        cmt_step;
    logic [POLL_W-1:0] poll_cnt;
    logic [POLL_W-1:0] limit_q;
    logic              count_ok;
    logic              poll_exhausted;

    assign count_ok       = (req_count != '0) && (req_count <= CNT_W'(MAX_BYTES));
    assign poll_exhausted = (({1'b0, poll_cnt} + 1'b1) >= {1'b0, limit_q});
    assign ser_load       = (state == ST_IDLE) && req_valid && count_ok;
    assign ser_step       = cyc_done && ((state == ST_ADDR) || (state == ST_DATA));
    assign busy           = (state != ST_IDLE);

    // Describe the bus cycle that the current step needs.
    always_comb begin
        desc = '0;
        unique case (state)
            ST_RESET: begin
                desc.is_write = RST_WR[rst_step];
                desc.wbit     = RST_VAL[rst_step];
            end
            ST_ADDR, ST_DATA: begin
                desc.is_write = 1'b1;
                desc.wbit     = ser_bit;
            end
            ST_COMMIT: begin
                desc.is_write = (cmt_step == 2'd1);
                desc.wbit     = (cmt_step == 2'd1);
            end
            default: desc = '0;
        endcase
    end

    // Step sequencing, cycle launch and outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            rst_step    <= '0;
            cmt_step    <= '0;
            poll_cnt    <= '0;
            limit_q     <= '0;
            go          <= 1'b0;
            done        <= 1'b0;
            err_timeout <= 1'b0;
            err_reject  <= 1'b0;
        end else begin
            go          <= 1'b0;
            done        <= 1'b0;
            err_timeout <= 1'b0;
            err_reject  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (count_ok) begin
                            state    <= ST_RESET;
                            rst_step <= '0;
                            limit_q  <= req_poll_limit;
                            go       <= 1'b1;
                        end else begin
                            err_reject <= 1'b1;
                        end
                    end
                end
                ST_RESET: begin
                    if (cyc_done) begin
                        go <= 1'b1;
                        if (rst_step == RW'(RST_LEN - 1)) begin
                            state <= ST_ADDR;
                        end else begin
                            rst_step <= rst_step + 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    if (cyc_done) begin
                        go <= 1'b1;
                        if (addr_last) begin
                            state <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (cyc_done) begin
                        go <= 1'b1;
                        if (data_last) begin
                            state    <= ST_COMMIT;
                            cmt_step <= '0;
                        end
                    end
                end
                ST_COMMIT: begin
                    if (cyc_done) begin
                        go <= 1'b1;
                        if (cmt_step == 2'd2) begin
                            state    <= ST_POLL;
                            poll_cnt <= '0;
                        end else begin
                            cmt_step <= cmt_step + 1'b1;
                        end
                    end
                end
                ST_POLL: begin
                    if (cyc_done) begin
                        if (rd_bit) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else if (poll_exhausted) begin
                            state       <= ST_IDLE;
                            err_timeout <= 1'b1;
                        end else begin
                            poll_cnt <= poll_cnt + 1'b1;
                            go       <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pgwr_seq.sv
// Serial page write sequencer top: ties the controller, the bit
// serializer and the bus cycle engine together.
// Assumes a host buffer with a combinational read port and a memory that
// holds the data pin low while its internal write is in progress.
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int                 ADDR_W    = 16,
    parameter int                 MAX_BYTES = 32,
    parameter int                 POLL_W    = 16,
    parameter int                 RST_LEN   = 3,
    parameter logic [RST_LEN-1:0] RST_WR    = 3'b010,
    parameter logic [RST_LEN-1:0] RST_VAL   = 3'b000,
    parameter int                 T_SETUP   = 1,
    parameter int                 T_STROBE  = 2,
    parameter int                 T_HOLD    = 1,
    parameter int                 T_GAP     = 1,
    localparam int                CNT_W     = $clog2(MAX_BYTES + 1),
    localparam int                IDX_W     = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [POLL_W-1:0] req_poll_limit,
    output logic [IDX_W-1:0]  buf_idx,
    input  logic [7:0]        buf_byte,
    output logic              busy,
    output logic              done,
    output logic              err_timeout,
    output logic              err_reject,
    output logic              bus_ce_n,
    output logic              bus_we_n,
    output logic              bus_oe_n,
    output logic              bus_dq_out,
    output logic              bus_dq_oe,
    input  logic              bus_dq_in
);

    logic      ser_load;
    logic      ser_step;
    logic      ser_bit;
    logic      addr_last;
    logic      data_last;
    logic      go;
    logic      cyc_done;
    logic      rd_bit;
    cyc_desc_t desc;

    pgwr_ctrl #(
        .MAX_BYTES (MAX_BYTES),
        .CNT_W     (CNT_W),
        .POLL_W    (POLL_W),
        .RST_LEN   (RST_LEN),
        .RST_WR    (RST_WR),
        .RST_VAL   (RST_VAL)
    ) ctrl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_count      (req_count),
        .req_poll_limit (req_poll_limit),
        .cyc_done       (cyc_done),
        .rd_bit         (rd_bit),
        .addr_last      (addr_last),
        .data_last      (data_last),
        .ser_bit        (ser_bit),
        .ser_load       (ser_load),
        .ser_step       (ser_step),
        .go             (go),
        .desc           (desc),
        .busy           (busy),
        .done           (done),
        .err_timeout    (err_timeout),
        .err_reject     (err_reject)
    );

    pgwr_serializer #(
        .ADDR_W    (ADDR_W),
        .MAX_BYTES (MAX_BYTES),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) ser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ser_load),
        .addr      (req_addr),
        .count     (req_count),
        .step      (ser_step),
        .buf_byte  (buf_byte),
        .buf_idx   (buf_idx),
        .bit_out   (ser_bit),
        .addr_last (addr_last),
        .data_last (data_last)
    );

    pgwr_bus_cycle #(
        .T_SETUP  (T_SETUP),
        .T_STROBE (T_STROBE),
        .T_HOLD   (T_HOLD),
        .T_GAP    (T_GAP)
    ) bus_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .desc     (desc),
        .dq_in    (bus_dq_in),
        .ce_n     (bus_ce_n),
        .we_n     (bus_we_n),
        .oe_n     (bus_oe_n),
        .dq_out   (bus_dq_out),
        .dq_oe    (bus_dq_oe),
        .rd_bit   (rd_bit),
        .cyc_done (cyc_done)
    );

endmodule

// File: rtl/pgwr_seq_chk.sv
// Property checker for the page write sequencer, bound to its top.
// Observes only the top-level ports.
module pgwr_seq_chk #(
    parameter int CNT_W     = 6,
    parameter int MAX_BYTES = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [CNT_W-1:0] req_count,
    input logic             busy,
    input logic             done,
    input logic             err_timeout,
    input logic             err_reject,
    input logic             bus_ce_n,
    input logic             bus_we_n,
    input logic             bus_oe_n,
    input logic             bus_dq_out,
    input logic             bus_dq_oe
);

    a_r1_idle_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_ce_n && bus_we_n && bus_oe_n && !bus_dq_oe));

    a_r2_reject_bad_count: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && ((req_count == '0) || (req_count > CNT_W'(MAX_BYTES))))
        |=> (err_reject && !busy));

    a_r4_write_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> (!bus_ce_n && bus_oe_n && bus_dq_oe));

    a_r4_bit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we_n && $past(!bus_we_n)) |-> $stable(bus_dq_out));

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r10_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_n |-> (!bus_dq_oe && !bus_ce_n));

    a_r10_release_between: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ce_n |-> !bus_dq_oe);

    a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_we_n && !bus_oe_n));

    a_r11_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ce_n) |=> bus_ce_n);

    a_r12_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_timeout, err_reject}));

endmodule

bind pgwr_seq pgwr_seq_chk #(
    .CNT_W     (CNT_W),
    .MAX_BYTES (MAX_BYTES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_count   (req_count),
    .busy        (busy),
    .done        (done),
    .err_timeout (err_timeout),
    .err_reject  (err_reject),
    .bus_ce_n    (bus_ce_n),
    .bus_we_n    (bus_we_n),
    .bus_oe_n    (bus_oe_n),
    .bus_dq_out  (bus_dq_out),
    .bus_dq_oe   (bus_dq_oe)
);

// File: tb/pgwr_seq_tb_top.sv
// Self-checking bench: random and directed page write requests, a bus
// monitor that logs every strobe, and a memory model that releases the
// data pin after a chosen number of status reads.
module pgwr_seq_tb_top;

    localparam int PRE_READS = 2;   // reads in the default preamble
    localparam int LOG_MAX   = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [5:0]  req_count = '0;
    logic [15:0] req_poll_limit = '0;
    logic [4:0]  buf_idx;
    logic [7:0]  buf_byte;
    logic        busy, done, err_timeout, err_reject;
    logic        bus_ce_n, bus_we_n, bus_oe_n, bus_dq_out, bus_dq_oe;
    logic        bus_dq_in = 1'b0;

    logic [7:0]  buf_mem [0:31];
    assign buf_byte = buf_mem[buf_idx];

    always #2 clk = ~clk;

    pgwr_seq dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_count      (req_count),
        .req_poll_limit (req_poll_limit),
        .buf_idx        (buf_idx),
        .buf_byte       (buf_byte),
        .busy           (busy),
        .done           (done),
        .err_timeout    (err_timeout),
        .err_reject     (err_reject),
        .bus_ce_n       (bus_ce_n),
        .bus_we_n       (bus_we_n),
        .bus_oe_n       (bus_oe_n),
        .bus_dq_out     (bus_dq_out),
        .bus_dq_oe      (bus_dq_oe),
        .bus_dq_in      (bus_dq_in)
    );

    int checks = 0;
    int fails  = 0;

    // Bus monitor state.
    bit log_wr  [0:LOG_MAX-1];
    bit log_val [0:LOG_MAX-1];
    int log_n = 0;
    int v_r4 = 0, v_r10 = 0, v_r11 = 0;
    int strobes_win = 0;
    int reads_seen = 0;
    int busy_polls = 0;
    logic prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1, prev_dq = 1'b0;

    // Expected cycle list.
    bit exp_wr  [0:LOG_MAX-1];
    bit exp_val [0:LOG_MAX-1];
    int exp_n = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Log strobes, check pin framing and play the memory's status pin.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!bus_we_n && (bus_ce_n || !bus_oe_n || !bus_dq_oe)) v_r4++;
            if (!bus_we_n && !prev_we && (bus_dq_out != prev_dq)) v_r4++;
            if (!bus_oe_n && bus_dq_oe) v_r10++;
            if (bus_ce_n && bus_dq_oe) v_r10++;
            if (!bus_we_n && !bus_oe_n) v_r11++;
            if (!bus_we_n && prev_we) begin
                if (log_n < LOG_MAX) begin
                    log_wr[log_n] = 1'b1;
                    log_val[log_n] = bus_dq_out;
                end
                log_n++;
                strobes_win++;
            end
            if (!bus_oe_n && prev_oe) begin
                if (log_n < LOG_MAX) begin
                    log_wr[log_n] = 1'b0;
                    log_val[log_n] = 1'b0;
                end
                log_n++;
                strobes_win++;
                reads_seen++;
            end
            if (bus_ce_n && !prev_ce) begin
                if (strobes_win != 1) v_r11++;
                strobes_win = 0;
            end
            bus_dq_in = (reads_seen > PRE_READS + 2 + busy_polls);
        end
        prev_we = bus_we_n;
        prev_oe = bus_oe_n;
        prev_ce = bus_ce_n;
        prev_dq = bus_dq_out;
    end

    task automatic push_exp(input bit wr, input bit val);
        exp_wr[exp_n] = wr;
        exp_val[exp_n] = val;
        exp_n++;
    endtask

    // Build the cycle list that the requirements call for.
    task automatic build_exp(input logic [15:0] addr, input int cnt, input int npoll);
        exp_n = 0;
        push_exp(1'b0, 1'b0); push_exp(1'b1, 1'b0); push_exp(1'b0, 1'b0);
        for (int i = 15; i >= 0; i--) push_exp(1'b1, addr[i]);
        for (int b = 0; b < cnt; b++)
            for (int k = 7; k >= 0; k--) push_exp(1'b1, buf_mem[b][k]);
        push_exp(1'b0, 1'b0); push_exp(1'b1, 1'b1); push_exp(1'b0, 1'b0);
        for (int p = 0; p < npoll; p++) push_exp(1'b0, 1'b0);
    endtask

    function automatic int expected_polls(input int limit, input int bp);
        int lim;
        lim = (limit == 0) ? 1 : limit;
        return (bp < lim) ? bp + 1 : lim;
    endfunction

    task automatic clear_monitor(input int bp);
        log_n = 0; v_r4 = 0; v_r10 = 0; v_r11 = 0;
        reads_seen = 0; busy_polls = bp; bus_dq_in = 1'b0;
    endtask

    // One accepted request followed by a full comparison.
    task automatic run_req(input logic [15:0] addr, input int cnt,
                           input int limit, input int bp);
        int lim, npoll, cyc, mm_pre, mm_addr, mm_data, mm_cmt, mm_poll, rd_mid, n_after;
        bit succ, got_done, got_to;
        lim = (limit == 0) ? 1 : limit;
        succ = (bp < lim);
        npoll = expected_polls(limit, bp);
        clear_monitor(bp);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_count = 6'(cnt);
        req_poll_limit = 16'(limit);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R8", "busy after accept", int'(busy), 1);
        got_done = 0; got_to = 0; cyc = 0;
        while (!got_done && !got_to && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            got_done = done;
            got_to = err_timeout;
            if (done || err_timeout)
                check(busy == 1'b0, "R8", "busy at outcome", int'(busy), 0);
        end
        if (succ) check(got_done && !got_to, "R8", "done outcome", int'(got_done), 1);
        else      check(got_to && !got_done, "R9", "timeout outcome", int'(got_to), 1);
        @(negedge clk);
        check(!done && !err_timeout, "R12", "pulse width", int'(done | err_timeout), 0);
        n_after = log_n;
        repeat (12) @(negedge clk);
        check(log_n == n_after, "R9", "cycles after outcome", log_n, n_after);
        build_exp(addr, cnt, npoll);
        check(log_n == exp_n, "R3", "cycle count", log_n, exp_n);
        mm_pre = 0; mm_addr = 0; mm_data = 0; mm_cmt = 0; mm_poll = 0; rd_mid = 0;
        for (int i = 0; i < exp_n && i < log_n && i < LOG_MAX; i++) begin
            bit bad;
            bad = (log_wr[i] != exp_wr[i]) || (log_val[i] != exp_val[i]);
            if (i < 3) mm_pre += int'(bad);
            else if (i < 19) mm_addr += int'(bad);
            else if (i < 19 + 8 * cnt) mm_data += int'(bad);
            else if (i < 22 + 8 * cnt) mm_cmt += int'(bad);
            else mm_poll += int'(bad);
            if (i >= 3 && i < 19 + 8 * cnt && !log_wr[i]) rd_mid++;
        end
        check(mm_pre == 0, "R3", "preamble mismatches", mm_pre, 0);
        check(mm_addr == 0, "R5", "address bit mismatches", mm_addr, 0);
        check(mm_data == 0, "R5", "payload bit mismatches", mm_data, 0);
        check(rd_mid == 0, "R6", "reads inside address/payload", rd_mid, 0);
        check(mm_cmt == 0, "R7", "commit mismatches", mm_cmt, 0);
        check(mm_poll == 0, "R8", "status read mismatches", mm_poll, 0);
        check(v_r4 == 0, "R4", "write frame violations", v_r4, 0);
        check(v_r10 == 0, "R10", "pin enable violations", v_r10, 0);
        check(v_r11 == 0, "R11", "strobe window violations", v_r11, 0);
    endtask

    // One request with an out-of-range count.
    task automatic run_reject(input int cnt);
        clear_monitor(0);
        @(negedge clk);
        req_valid = 1'b1; req_count = 6'(cnt); req_addr = 16'hFFFF;
        req_poll_limit = 16'd4;
        @(negedge clk);
        req_valid = 1'b0;
        check(err_reject == 1'b1, "R2", "reject pulse", int'(err_reject), 1);
        check(busy == 1'b0, "R2", "busy on reject", int'(busy), 0);
        @(negedge clk);
        check(err_reject == 1'b0, "R12", "reject pulse width", int'(err_reject), 0);
        repeat (20) @(negedge clk);
        check(log_n == 0, "R2", "bus cycles on reject", log_n, 0);
    endtask

    task automatic fill_buf();
        for (int i = 0; i < 32; i++) buf_mem[i] = 8'($urandom_range(0, 255));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd7321));
        fill_buf();
        repeat (3) @(negedge clk);
        check(bus_ce_n && bus_we_n && bus_oe_n, "R1", "strobes in reset",
              int'({bus_ce_n, bus_we_n, bus_oe_n}), 7);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_ce_n && bus_we_n && bus_oe_n, "R1", "strobes after reset",
              int'({bus_ce_n, bus_we_n, bus_oe_n}), 7);
        check(!bus_dq_oe, "R1", "pin enable after reset", int'(bus_dq_oe), 0);
        check(!busy, "R1", "busy after reset", int'(busy), 0);

        // Directed corner cases.
        run_reject(0);
        run_reject(33);
        run_reject(63);
        run_req(16'h8001, 1, 4, 0);
        run_req(16'hA5C3, 32, 3, 2);
        run_req(16'h0000, 2, 0, 0);
        run_req(16'h7FFE, 3, 0, 5);
        run_req(16'h1234, 4, 3, 3);
        run_req(16'hFFFF, 1, 1, 1);

        // Constrained random requests.
        for (int n = 0; n < 16; n++) begin
            fill_buf();
            run_req(16'($urandom_range(0, 65535)), int'($urandom_range(1, 32)),
                    int'($urandom_range(0, 6)), int'($urandom_range(0, 7)));
        end
        finish_run();
    end

endmodule